// File: doc/BRIEF.md
# Two-Mode Word Address Generator

This block forms the memory addresses for a 30-bit word processor that can run with either a short or a long address space. It keeps the program counter and a small bank of extension registers. Every clock it registers an instruction address, which is the program counter, and an operand address, which it builds from a 15-bit operand field.

In short mode the program counter and the operand address stay inside a 32K-word space. In long mode the counter grows to 18 bits. The top two bits of the operand field then pick a 5-bit extension value. That value is placed above the low 13 bits of the field, so an operand can reach any word of a 256K-word space. Selector code 00 always means extension zero, so the bottom 8K words can be reached without setting up a register.

Software sets the mode, steps or loads the counter, and writes the extension registers through a small write port. Instruction decode, memory and protection logic sit outside this block.

Top module: `word_addr_gen`

## Requirements
- R1: After reset the block is in short mode. Both address outputs read zero, and extension registers 1 to 3 hold zero.
- R2: In short mode (`long_mode_i`=0) an increment advances the 15-bit counter, and 0x7FFF steps to 0x0000.
- R3: In short mode the operand address on the next cycle is `opnd_y_i` zero-extended to 18 bits.
- R4: In long mode (`long_mode_i`=1) the counter is 18 bits wide. An increment steps 0x07FFF to 0x08000 and 0x3FFFF to 0x00000, and with neither increment nor load the counter holds.
- R5: In long mode a selector `opnd_y_i[14:13]` of 1, 2 or 3 gives an operand address of {extension register[selector], `opnd_y_i[12:0]`}, with the 5-bit extension value in bits 17:13.
- R6: In long mode selector 00 gives an operand address whose bits 17:13 are zero and whose bits 12:0 are `opnd_y_i[12:0]`.
- R7: A write (`ext_wr_i`=1, index `ext_idx_i`, value `ext_val_i`) changes the extension register at the clock edge. An operand address formed in the same cycle uses the old value. A write to index 0 has no effect.
- R8: `pc_load_i` loads `pc_target_i` and wins over `pc_step_i` in the same cycle. In short mode only the low 15 bits of the target are kept.
- R9: Going from long to short mode clears counter bits 17:15 on that edge. Going from short to long mode keeps the counter value, zero-extended.
- R10: Whenever the mode input was short on an edge, bits 17:15 of both outputs are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_mode_i | input | 1 | 1 selects the 18-bit address space |
| pc_step_i | input | 1 | Increment the program counter |
| pc_load_i | input | 1 | Load the program counter |
| pc_target_i | input | 18 | Jump target for a load |
| ext_wr_i | input | 1 | Extension register write enable |
| ext_idx_i | input | 2 | Extension register index |
| ext_val_i | input | 5 | Value to write |
| opnd_y_i | input | 15 | Operand address field |
| instr_addr_o | output | 18 | Registered instruction address (program counter) |
| opnd_addr_o | output | 18 | Registered operand address |

## Verification
The bench builds the block with its default parameters: a 15-bit operand field, a 13-bit low part and 5-bit extensions. This gives an 18-bit space with three writable extension registers. At these widths both counter wrap points (0x7FFF and 0x3FFFF) are one load and a few steps away. All four selector codes, the same-cycle write hazard and the writes to index 0 can be driven directly. A long run of random mixed traffic then crosses mode changes while the counter sits at arbitrary values.

// File: rtl/word_addr_gen.sv
module word_addr_gen #(
  parameter int Y_W   = 15,
  parameter int LOW_W = 13,
  parameter int EXT_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     long_mode_i,
  input  logic                     pc_step_i,
  input  logic                     pc_load_i,
  input  logic [LOW_W+EXT_W-1:0]   pc_target_i,
  input  logic                     ext_wr_i,
  input  logic [Y_W-LOW_W-1:0]     ext_idx_i,
  input  logic [EXT_W-1:0]         ext_val_i,
  input  logic [Y_W-1:0]           opnd_y_i,
  output logic [LOW_W+EXT_W-1:0]   instr_addr_o,
  output logic [LOW_W+EXT_W-1:0]   opnd_addr_o
);
  localparam int PA_W    = LOW_W + EXT_W;
  localparam int SEL_W   = Y_W - LOW_W;
  localparam int HI_W    = PA_W - Y_W;
  localparam int NUM_SEL = 1 << SEL_W;

  logic [PA_W-1:0]  pc_q, pc_base, pc_nxt, oa_q, oa_nxt;
  logic [EXT_W-1:0] ext_q [NUM_SEL];
  logic [SEL_W-1:0] sel;

  assign sel     = opnd_y_i[Y_W-1:LOW_W];
  assign pc_base = pc_load_i ? pc_target_i : (pc_step_i ? pc_q + PA_W'(1) : pc_q);
  assign pc_nxt  = long_mode_i ? pc_base : {{HI_W{1'b0}}, pc_base[Y_W-1:0]};
  assign oa_nxt  = long_mode_i ? {ext_q[sel], opnd_y_i[LOW_W-1:0]}
                               : {{HI_W{1'b0}}, opnd_y_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
      oa_q <= '0;
    end else begin
      pc_q <= pc_nxt;
      oa_q <= oa_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEL; i++) ext_q[i] <= '0;
    end else if (ext_wr_i) begin
      for (int i = 1; i < NUM_SEL; i++)
        if (ext_idx_i == SEL_W'(i)) ext_q[i] <= ext_val_i;
    end
  end

  assign instr_addr_o = pc_q;
  assign opnd_addr_o  = oa_q;
endmodule

module word_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        long_mode_i,
  input logic        pc_step_i,
  input logic        pc_load_i,
  input logic [17:0] pc_target_i,
  input logic [14:0] opnd_y_i,
  input logic [17:0] instr_addr_o,
  input logic [17:0] opnd_addr_o
);
  a_r2_short_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_mode_i && pc_step_i && !pc_load_i) |=>
      instr_addr_o == {3'b000, 15'($past(instr_addr_o[14:0]) + 15'd1)});

  a_r3_short_operand: assert property (@(posedge clk) disable iff (!rst_n)
    !long_mode_i |=> opnd_addr_o == {3'b000, $past(opnd_y_i)});

  a_r4_long_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (long_mode_i && !pc_step_i && !pc_load_i) |=> $stable(instr_addr_o));

  a_r6_sel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (long_mode_i && opnd_y_i[14:13] == 2'b00) |=>
      opnd_addr_o == {5'd0, $past(opnd_y_i[12:0])});

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_i && long_mode_i) |=> instr_addr_o == $past(pc_target_i));

  a_r10_short_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !long_mode_i |=> (instr_addr_o[17:15] == 3'b000 && opnd_addr_o[17:15] == 3'b000));
endmodule

bind word_addr_gen word_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .long_mode_i(long_mode_i), .pc_step_i(pc_step_i),
  .pc_load_i(pc_load_i), .pc_target_i(pc_target_i), .opnd_y_i(opnd_y_i),
  .instr_addr_o(instr_addr_o), .opnd_addr_o(opnd_addr_o));

// File: tb/test_word_addr_gen.sv
`timescale 1ns/1ps
module test_word_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic long_mode_i = 0, pc_step_i = 0, pc_load_i = 0, ext_wr_i = 0;
  logic [17:0] pc_target_i = '0;
  logic [1:0]  ext_idx_i = '0;
  logic [4:0]  ext_val_i = '0;
  logic [14:0] opnd_y_i = '0;
  logic [17:0] instr_addr_o, opnd_addr_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pc = 0, m_oa = 0;
  int m_ext [4] = '{0, 0, 0, 0};

  always #2 clk = ~clk;

  word_addr_gen i_word_addr_gen (
    .clk(clk), .rst_n(rst_n), .long_mode_i(long_mode_i), .pc_step_i(pc_step_i),
    .pc_load_i(pc_load_i), .pc_target_i(pc_target_i), .ext_wr_i(ext_wr_i),
    .ext_idx_i(ext_idx_i), .ext_val_i(ext_val_i), .opnd_y_i(opnd_y_i),
    .instr_addr_o(instr_addr_o), .opnd_addr_o(opnd_addr_o));

  task automatic compare(string tag);
    checks++;
    if (int'(instr_addr_o) != m_pc) begin
      errors++;
      $display("FAIL %s instr_addr actual=%05h expected=%05h", tag, instr_addr_o, m_pc);
    end
    checks++;
    if (int'(opnd_addr_o) != m_oa) begin
      errors++;
      $display("FAIL %s opnd_addr actual=%05h expected=%05h", tag, opnd_addr_o, m_oa);
    end
  endtask

  task automatic cyc(bit md, bit st, bit ld, int tgt, bit we, int idx, int ev, int y, string tag);
    int base, sel, up;
    long_mode_i = md; pc_step_i = st; pc_load_i = ld; pc_target_i = 18'(tgt);
    ext_wr_i = we; ext_idx_i = 2'(idx); ext_val_i = 5'(ev); opnd_y_i = 15'(y);
    @(posedge clk);
    base = ld ? tgt : (st ? m_pc + 1 : m_pc);
    m_pc = md ? (base & 'h3FFFF) : (base & 'h7FFF);
    sel  = (y >> 13) & 3;
    up   = (sel == 0) ? 0 : m_ext[sel];
    m_oa = md ? ((up << 13) | (y & 'h1FFF)) : (y & 'h7FFF);
    if (we && idx != 0) m_ext[idx] = ev & 'h1F;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    for (int s = 1; s < 4; s++) cyc(1, 0, 0, 0, 0, 0, 0, (s << 13) | 'h0AA, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, 'h7FFF, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 'h1234, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 'h6ABC, "R3");
    cyc(0, 0, 1, 'h3FFFD, 0, 0, 0, 0, "R8");
    for (int k = 0; k < 4; k++) cyc(0, 1, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, 1, 1, 'h00100, 0, 0, 0, 0, "R8");
    cyc(1, 1, 1, 'h2F0F0, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 1, 1, 'h15, (1 << 13) | 'h1111, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, (1 << 13) | 'h1111, "R7");
    cyc(1, 0, 0, 0, 1, 2, 'h0A, (2 << 13) | 'h0F0F, "R7");
    cyc(1, 0, 0, 0, 1, 3, 'h1F, (3 << 13) | 'h1FFF, "R7");
    cyc(1, 0, 0, 0, 1, 0, 'h1F, 'h1ABC, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, 'h1ABC, "R6");
    cyc(1, 0, 0, 0, 0, 0, 0, 'h0000, "R6");
    for (int s = 1; s < 4; s++) cyc(1, 0, 0, 0, 0, 0, 0, (s << 13) | 'h0155, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, (3 << 13) | 'h1FFF, "R10");
    cyc(1, 0, 1, 'h07FFF, 0, 0, 0, 0, "R4");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 1, 'h3FFFE, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 1, 'h2ABCD, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 1, 'h1FFFF, 0, 0, 0, 0, "R9");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R9");
    for (int k = 0; k < 1500; k++)
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
          int'($urandom_range(0, 'h3FFFF)), ($urandom_range(0, 3) == 0),
          int'($urandom_range(0, 3)), int'($urandom_range(0, 31)),
          int'($urandom_range(0, 'h7FFF)), "R5_mix");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule